// File: doc/BRIEF.md
# Glitch-Free Power-Down Clock Stopper

This block sits between a clock synthesizer and its output pins. It shuts every generated clock down cleanly when an active-low power-down request arrives, and it brings the clocks back just as cleanly when the request is removed. The inputs are a free-running sequencer clock, a differential CPU clock pair, a set of ordinary single-ended clocks and a reference clock. The request may change at any moment relative to all of these clocks.

The request is confirmed in the CPU complement clock domain. A sequencer in the source clock domain then tells each output lane to park. Each lane resynchronizes that command in its own clock domain and changes its gate only while its own clock is at the parking level. The sequencer powers down the VCO/PLL only after every lane has reported that it is parked. On release, the sequence runs in reverse. The PLL control is removed first. After a programmable lock wait, the lanes are let go, and each one restarts with a full-width pulse.

Top module: `clock_stopper`

## Requirements
- R1: `pd_req_n` is active low and asynchronous. Power-down is confirmed only when two consecutive rising edges of `cpu_c_in` both sample it low. A low pulse that only one such edge sees has no effect.
- R2: Once power-down is confirmed, each bit of `gen_out` stops at a falling edge of its input clock and then stays low. Every high pulse it produces lasts exactly one input half period.
- R3: While the CPU lane is parked, `cpu_t_out` is held high, `cpu_c_out` is low and `cpu_c_oe` is 0 (the pin is undriven). Every low pulse of `cpu_t_out` and every high pulse of `cpu_c_out` lasts a full input half period.
- R4: `ref_out` parks low on a falling edge of `ref_in`. Its command synchronizer has `REF_SYNC_STAGES` stages (default 3), so it takes more of its own cycles to stop than the other lanes do.
- R5: `pll_pd` rises only after every lane has reached its parked state. No output edge occurs from then until release.
- R6: When the request goes high again, `pll_pd` falls first. The lanes stay parked for at least `LOCK_CYCLES` cycles of `clk_src` after that.
- R7: After the lock wait, every lane restarts from its parked level. The first edge of each lane is a full-width one, and `cpu_c_oe` returns to 1.
- R8: `all_stopped` is 1 only while every lane is parked and `pll_pd` is 1. It falls in the same cycle that `pll_pd` falls.
- R9: While `rst_n` is low, all clocks pass through, `pll_pd` and `all_stopped` are 0 and `cpu_c_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running clock for the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| cpu_t_in | input | 1 | CPU clock, true side |
| cpu_c_in | input | 1 | CPU clock, complement side |
| gen_in | input | NUM_GEN | Ordinary single-ended clocks |
| ref_in | input | 1 | Reference clock |
| cpu_t_out | output | 1 | Gated CPU true clock (parks high) |
| cpu_c_out | output | 1 | Gated CPU complement clock |
| cpu_c_oe | output | 1 | Drive enable for the complement pin; 0 means undriven |
| gen_out | output | NUM_GEN | Gated single-ended clocks (park low) |
| ref_out | output | 1 | Gated reference clock (parks low) |
| pll_pd | output | 1 | Powers down the VCO/PLL when 1 |
| all_stopped | output | 1 | Status: every lane is parked and the PLL is down |

## Verification
The bench drives the request at ten different phases against the CPU complement clock. Its low pulse is placed so that exactly one sampling edge sees it, which would expose a design that confirms power-down on a single sample. It measures the width of every pulse on every output lane. A gate that closed or opened on the wrong edge would cut off a high pulse, or on the CPU pair a low pulse, and the bench would catch it. It timestamps the fall of `pll_pd` and the first output edge that follows. A design that skipped or shortened the lock wait, or lowered the PLL control only after restarting, would show that gap too short. It also counts output edges from the rise of `pll_pd` onward, which catches a design that powers the PLL down before every lane has settled.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOPPING,
    ST_PARKED,
    ST_LOCKWAIT,
    ST_RESUMING
  } cs_state_e;
endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
// Multi-stage flop chain used at every clock domain crossing.
module cs_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= {WIDTH{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cs_pd_detect.sv
`timescale 1ns/1ps
// Confirms the request in the CPU complement domain: two consecutive low
// samples set the flag, two consecutive high samples clear it.
module cs_pd_detect (
  input  logic cpu_c_in,
  input  logic rst_n,
  input  logic pd_req_n,
  output logic pd_confirm
);
  logic [1:0] smp;

  always_ff @(posedge cpu_c_in or negedge rst_n) begin
    if (!rst_n) begin
      smp        <= 2'b11;
      pd_confirm <= 1'b0;
    end else begin
      smp <= {smp[0], pd_req_n};
      if (smp == 2'b00)      pd_confirm <= 1'b1;
      else if (smp == 2'b11) pd_confirm <= 1'b0;
    end
  end
endmodule

// File: rtl/cs_lane.sv
`timescale 1ns/1ps
// Single-ended lane: parks low. The gate changes only on the falling edge
// of the lane's own clock, so the output can never show a clipped pulse.
module cs_lane #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic stop_req,
  output logic clk_out,
  output logic stopped
);
  logic stop_l;
  logic en;

  cs_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk_in), .rst_n(rst_n), .d(stop_req), .q(stop_l)
  );

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en <= 1'b1;
    else        en <= !stop_l;
  end

  assign clk_out = clk_in & en;
  assign stopped = !en;
endmodule

// File: rtl/cs_cpu_lane.sv
`timescale 1ns/1ps
// Differential CPU lane. The gate moves on the falling edge of the
// complement clock, which is when the true side has just gone high:
// true parks high, complement parks low and its driver is released.
module cs_cpu_lane #(
  parameter int STAGES = 2
) (
  input  logic cpu_t_in,
  input  logic cpu_c_in,
  input  logic rst_n,
  input  logic stop_req,
  output logic cpu_t_out,
  output logic cpu_c_out,
  output logic cpu_c_oe,
  output logic stopped
);
  logic stop_l;
  logic en;

  cs_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(cpu_c_in), .rst_n(rst_n), .d(stop_req), .q(stop_l)
  );

  always_ff @(negedge cpu_c_in or negedge rst_n) begin
    if (!rst_n) en <= 1'b1;
    else        en <= !stop_l;
  end

  assign cpu_t_out = en ? cpu_t_in : 1'b1;
  assign cpu_c_out = cpu_c_in & en;
  assign cpu_c_oe  = en;
  assign stopped   = !en;
endmodule

// File: rtl/cs_ctrl.sv
`timescale 1ns/1ps
// Source-domain sequencer: stop lanes, wait for all parked, power down
// PLL; on release power PLL up, wait lock, then free the lanes.
module cs_ctrl
  import cs_pkg::*;
#(
  parameter int NUM_LANES   = 5,
  parameter int LOCK_CYCLES = 64
) (
  input  logic                 clk_src,
  input  logic                 rst_n,
  input  logic                 pd_confirm,
  input  logic [NUM_LANES-1:0] lane_stopped,
  output logic                 stop_req,
  output logic                 pll_pd,
  output logic                 all_stopped,
  output logic                 lanes_parked
);
  localparam int CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic                 confirm_s;
  logic [NUM_LANES-1:0] stopped_s;
  cs_state_e            state, state_d;
  logic [CW-1:0]        cnt;

  cs_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_sync_pd (
    .clk(clk_src), .rst_n(rst_n), .d(pd_confirm), .q(confirm_s)
  );

  cs_sync #(.WIDTH(NUM_LANES), .STAGES(2), .RST_VAL(1'b0)) u_sync_st (
    .clk(clk_src), .rst_n(rst_n), .d(lane_stopped), .q(stopped_s)
  );

  assign lanes_parked = &stopped_s;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_RUN:      if (confirm_s)          state_d = ST_STOPPING;
      ST_STOPPING: if (&stopped_s)         state_d = ST_PARKED;
      ST_PARKED:   if (!confirm_s)         state_d = ST_LOCKWAIT;
      ST_LOCKWAIT: if (cnt == LAST)        state_d = ST_RESUMING;
      ST_RESUMING: if (stopped_s == '0)    state_d = ST_RUN;
      default:                             state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      cnt         <= '0;
      stop_req    <= 1'b0;
      pll_pd      <= 1'b0;
      all_stopped <= 1'b0;
    end else begin
      state       <= state_d;
      cnt         <= (state == ST_LOCKWAIT) ? cnt + 1'b1 : '0;
      stop_req    <= (state_d == ST_STOPPING) || (state_d == ST_PARKED) ||
                     (state_d == ST_LOCKWAIT);
      pll_pd      <= (state_d == ST_PARKED);
      all_stopped <= (state_d == ST_PARKED) && (&stopped_s);
    end
  end
endmodule

// File: rtl/clock_stopper.sv
`timescale 1ns/1ps
module clock_stopper #(
  parameter int NUM_GEN         = 3,
  parameter int SYNC_STAGES     = 2,
  parameter int REF_SYNC_STAGES = 3,
  parameter int LOCK_CYCLES     = 64
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic               pd_req_n,
  input  logic               cpu_t_in,
  input  logic               cpu_c_in,
  input  logic [NUM_GEN-1:0] gen_in,
  input  logic               ref_in,
  output logic               cpu_t_out,
  output logic               cpu_c_out,
  output logic               cpu_c_oe,
  output logic [NUM_GEN-1:0] gen_out,
  output logic               ref_out,
  output logic               pll_pd,
  output logic               all_stopped
);
  localparam int NUM_LANES = NUM_GEN + 2;
  localparam int REF_IDX   = NUM_GEN;
  localparam int CPU_IDX   = NUM_GEN + 1;

  logic                 pd_confirm;
  logic                 stop_req;
  logic                 lanes_parked;
  logic [NUM_LANES-1:0] lane_stopped;

  cs_pd_detect u_detect (
    .cpu_c_in(cpu_c_in), .rst_n(rst_n), .pd_req_n(pd_req_n),
    .pd_confirm(pd_confirm)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    cs_lane #(.STAGES(SYNC_STAGES)) u_lane (
      .clk_in(gen_in[g]), .rst_n(rst_n), .stop_req(stop_req),
      .clk_out(gen_out[g]), .stopped(lane_stopped[g])
    );
  end

  cs_lane #(.STAGES(REF_SYNC_STAGES)) u_ref (
    .clk_in(ref_in), .rst_n(rst_n), .stop_req(stop_req),
    .clk_out(ref_out), .stopped(lane_stopped[REF_IDX])
  );

  cs_cpu_lane #(.STAGES(SYNC_STAGES)) u_cpu (
    .cpu_t_in(cpu_t_in), .cpu_c_in(cpu_c_in), .rst_n(rst_n),
    .stop_req(stop_req), .cpu_t_out(cpu_t_out), .cpu_c_out(cpu_c_out),
    .cpu_c_oe(cpu_c_oe), .stopped(lane_stopped[CPU_IDX])
  );

  cs_ctrl #(.NUM_LANES(NUM_LANES), .LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .clk_src(clk_src), .rst_n(rst_n), .pd_confirm(pd_confirm),
    .lane_stopped(lane_stopped), .stop_req(stop_req), .pll_pd(pll_pd),
    .all_stopped(all_stopped), .lanes_parked(lanes_parked)
  );
endmodule

// File: rtl/cs_checker.sv
`timescale 1ns/1ps
module cs_checker #(
  parameter int NUM_GEN     = 3,
  parameter int LOCK_CYCLES = 64
) (
  input logic               clk_src,
  input logic               rst_n,
  input logic               pll_pd,
  input logic               all_stopped,
  input logic               stop_req,
  input logic               lanes_parked,
  input logic [NUM_GEN-1:0] gen_out,
  input logic               ref_out,
  input logic               cpu_t_out,
  input logic               cpu_c_out,
  input logic               cpu_c_oe
);
  localparam int CW = $clog2(LOCK_CYCLES + 2);
  logic [CW-1:0] held_cnt;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n)                                  held_cnt <= '0;
    else if (pll_pd)                             held_cnt <= '0;
    else if (stop_req && held_cnt != CW'(LOCK_CYCLES)) held_cnt <= held_cnt + 1'b1;
  end

  AST_PD_AFTER_PARK: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(pll_pd) |-> lanes_parked); // R5
  AST_PD_HOLDS_LANES: assert property (@(posedge clk_src) disable iff (!rst_n)
    pll_pd |-> stop_req); // R5
  AST_STATUS_PARKED: assert property (@(posedge clk_src) disable iff (!rst_n)
    all_stopped |-> (gen_out == '0 && !ref_out && cpu_t_out && !cpu_c_out && !cpu_c_oe)); // R8
  AST_STATUS_CLEAR: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(all_stopped) |-> !pll_pd); // R8
  AST_PLL_UP_FIRST: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(pll_pd) |-> (stop_req && lanes_parked)); // R6
  AST_LOCK_WAIT: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(stop_req) |-> (held_cnt == CW'(LOCK_CYCLES))); // R6
endmodule

bind clock_stopper cs_checker #(.NUM_GEN(NUM_GEN), .LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .pll_pd(pll_pd), .all_stopped(all_stopped),
  .stop_req(stop_req), .lanes_parked(lanes_parked), .gen_out(gen_out),
  .ref_out(ref_out), .cpu_t_out(cpu_t_out), .cpu_c_out(cpu_c_out),
  .cpu_c_oe(cpu_c_oe)
);

// File: tb/sim_clock_stopper.sv
`timescale 1ns/1ps
module sim_clock_stopper;
  localparam int NG   = 3;
  localparam int LOCK = 16;
  localparam real SRC_PER = 4.0;

  logic clk_src = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req_n = 1'b1;
  logic cpu_t_in = 1'b0;
  logic cpu_c_in;
  logic g0 = 1'b0, g1 = 1'b0, g2 = 1'b0;
  logic ref_in = 1'b0;
  logic [NG-1:0] gen_in;
  logic cpu_t_out, cpu_c_out, cpu_c_oe, ref_out, pll_pd, all_stopped;
  logic [NG-1:0] gen_out;

  int  n_checks = 0, n_errors = 0;
  int  edge_cnt = 0, edges_at_pd = 0, pd_rises = 0;
  int  short_hi = 0, short_lo = 0, cpu_short = 0;
  bit  armed = 0, first_seen = 0;
  real t_pllf = 0.0, t_first = 0.0;

  always #2 clk_src = ~clk_src;
  initial begin #1.3; forever #5 cpu_t_in = ~cpu_t_in; end
  assign cpu_c_in = ~cpu_t_in;
  initial begin #0.7; forever #3 g0 = ~g0; end
  initial begin #1.4; forever #4 g1 = ~g1; end
  initial begin #2.1; forever #5 g2 = ~g2; end
  initial begin #2.6; forever #15 ref_in = ~ref_in; end
  assign gen_in = {g2, g1, g0};

  clock_stopper #(.NUM_GEN(NG), .SYNC_STAGES(2), .REF_SYNC_STAGES(3),
                  .LOCK_CYCLES(LOCK)) u0 (
    .clk_src(clk_src), .rst_n(rst_n), .pd_req_n(pd_req_n),
    .cpu_t_in(cpu_t_in), .cpu_c_in(cpu_c_in), .gen_in(gen_in), .ref_in(ref_in),
    .cpu_t_out(cpu_t_out), .cpu_c_out(cpu_c_out), .cpu_c_oe(cpu_c_oe),
    .gen_out(gen_out), .ref_out(ref_out), .pll_pd(pll_pd),
    .all_stopped(all_stopped)
  );

  task automatic note_edge();
    edge_cnt++;
    if (armed) begin armed = 0; first_seen = 1; t_first = $realtime; end
  endtask

  function automatic bit off(real w, real h);
    return (w - h > 0.01) || (h - w > 0.01);
  endfunction

  // pulse-width monitors: full high pulses (R2, R4), no short low gap (R7)
  for (genvar g = 0; g < NG; g++) begin : mon
    real tr = 0.0, tf = 0.0;
    bit  hv = 0, lv = 0;
    always @(posedge gen_out[g]) begin
      note_edge();
      if (lv && ($realtime - tf) < (3.0 + g) - 0.01) short_lo++;
      tr = $realtime; hv = 1;
    end
    always @(negedge gen_out[g]) begin
      note_edge();
      if (hv && off($realtime - tr, 3.0 + g)) short_hi++;
      tf = $realtime; lv = 1;
    end
  end

  real rtr = 0.0, rtf = 0.0;
  bit  rhv = 0, rlv = 0;
  always @(posedge ref_out) begin
    note_edge();
    if (rlv && ($realtime - rtf) < 15.0 - 0.01) short_lo++;
    rtr = $realtime; rhv = 1;
  end
  always @(negedge ref_out) begin
    note_edge();
    if (rhv && off($realtime - rtr, 15.0)) short_hi++;
    rtf = $realtime; rlv = 1;
  end

  real ctf = 0.0, ccr = 0.0;
  bit  clv = 0, chv = 0;
  always @(negedge cpu_t_out) begin note_edge(); ctf = $realtime; clv = 1; end
  always @(posedge cpu_t_out) begin
    note_edge();
    if (clv && off($realtime - ctf, 5.0)) cpu_short++;
  end
  always @(posedge cpu_c_out) begin ccr = $realtime; chv = 1; end
  always @(negedge cpu_c_out) if (chv && off($realtime - ccr, 5.0)) cpu_short++;

  always @(posedge pll_pd) begin pd_rises++; edges_at_pd = edge_cnt; end
  always @(negedge pll_pd) begin t_pllf = $realtime; armed = 1; end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * SRC_PER);
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int e0;
    // R9: reset state
    #30.5;
    check(pll_pd == 1'b0, "R9", "pll_pd in reset", pll_pd, 0);
    check(all_stopped == 1'b0, "R9", "all_stopped in reset", all_stopped, 0);
    check(cpu_c_oe == 1'b1, "R9", "cpu_c_oe in reset", cpu_c_oe, 1);
    check(edge_cnt > 4, "R9", "clocks pass in reset", edge_cnt, 5);
    #10.2 rst_n = 1'b1;
    #200;

    // R1: a low pulse seen by one sampling edge only
    @(posedge cpu_c_in);
    #1 pd_req_n = 1'b0;
    #10 pd_req_n = 1'b1;
    e0 = edge_cnt;
    #400;
    check(pd_rises == 0, "R1", "pll_pd rises after single sample", pd_rises, 0);
    check(all_stopped == 1'b0, "R1", "all_stopped after single sample", all_stopped, 0);
    check(edge_cnt > e0 + 50, "R1", "outputs keep running", edge_cnt - e0, 51);

    for (int p = 0; p < 10; p++) begin
      int k;
      @(posedge cpu_c_in);
      #(p * 1.0 + 0.6) pd_req_n = 1'b0;
      k = 0;
      while (!all_stopped && k < 3000) begin #1; k++; end
      #0.5;
      check(all_stopped == 1'b1, "R5", "all_stopped reached", all_stopped, 1);
      check(pll_pd == 1'b1, "R5", "pll_pd asserted", pll_pd, 1);
      check(gen_out == '0, "R2", "gen_out parked low", gen_out, 0);
      check(ref_out == 1'b0, "R4", "ref_out parked low", ref_out, 0);
      check(cpu_t_out == 1'b1 && cpu_c_out == 1'b0, "R3", "cpu pair park levels",
            {cpu_t_out, cpu_c_out}, 2);
      check(cpu_c_oe == 1'b0, "R3", "cpu_c_oe released", cpu_c_oe, 0);
      check(edge_cnt == edges_at_pd, "R5", "no edge after pll_pd rose",
            edge_cnt, edges_at_pd);
      e0 = edge_cnt;
      #200;
      check(edge_cnt == e0, "R2", "outputs stay parked", edge_cnt - e0, 0);
      check(pll_pd == 1'b1, "R5", "pll_pd held while request low", pll_pd, 1);

      first_seen = 0;
      #(p * 1.0 + 0.3) pd_req_n = 1'b1;
      k = 0;
      while (pll_pd && k < 500) begin #1; k++; end
      #0.5;
      check(pll_pd == 1'b0, "R6", "pll_pd released", pll_pd, 0);
      check(all_stopped == 1'b0, "R8", "all_stopped clears with pll_pd", all_stopped, 0);
      k = 0;
      while (!first_seen && k < 1000) begin #1; k++; end
      check(first_seen && (t_first - t_pllf) >= LOCK * SRC_PER - 0.01, "R6",
            "lock wait before first edge (ps)", int'((t_first - t_pllf) * 1000.0),
            int'(LOCK * SRC_PER * 1000.0));
      e0 = edge_cnt;
      #300;
      check(edge_cnt > e0 + 50, "R7", "outputs resumed", edge_cnt - e0, 51);
      check(cpu_c_oe == 1'b1, "R7", "cpu_c_oe restored", cpu_c_oe, 1);
    end

    check(short_hi == 0, "R2", "clipped high pulses", short_hi, 0);
    check(short_lo == 0, "R7", "short low gaps at restart", short_lo, 0);
    check(cpu_short == 0, "R3", "clipped cpu pair pulses", cpu_short, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule